// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Sequencer

This block brings up a downstream FPGA whose configuration port takes one byte per write cycle. On a start pulse it drives the active-low program line low for a programmable number of cycles, releases it, and waits for the target's active-low init line to go high. A programmable timeout bounds that wait. It then writes a fixed eight-byte header and turns a raw byte stream into configuration frames. Each frame carries a preamble, 21 payload bytes, a check code and a trailer that stretches the write cycle. Four startup bytes close the load.

Payload arrives on a valid/ready byte stream with a last-byte flag. The sequencer pulls a byte only when it is about to write it into a payload slot. It fills a partly used final frame with 0xFF. Before each frame it checks the init and done lines: if init has dropped, done has risen early, or the stream has ended, it goes straight to the startup bytes. Once the load ends it reports a sticky pass or fail flag that stays until the next start.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, program_n is high, wr_stb, busy, cfg_ok, cfg_err and s_ready are low.
- R2: A start pulse while idle drives program_n low for exactly PROG_LOW_CYC cycles, then high; cfg_ok and cfg_err clear at that start.
- R3: After program_n is released no write occurs until init_n is seen high; if it stays low for INIT_TMO_CYC cycles, cfg_err is set and busy drops with no write issued, so busy is high for PROG_LOW_CYC + INIT_TMO_CYC cycles.
- R4: The first eight writes are, in order, 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B.
- R5: Every frame is written as 0x4F, then 21 payload bytes, then 0x4B, then the trailer 0xFF, 0x4B, 0xFF, 0xFF, 0xFF.
- R6: Each write is a one-cycle wr_stb with wr_data valid in that cycle; at least GAP_CYC idle cycles separate two strobes, and exactly GAP_CYC inside header, frame and startup runs.
- R7: s_ready is high only in a payload slot of a frame and only before the byte flagged s_last has been taken; an accepted byte appears on wr_data with the next strobe, and payload slots left after s_last are written as 0xFF.
- R8: A new frame begins only if init_n is high, done is low and s_last has not yet been taken; otherwise the sequencer moves to the startup bytes.
- R9: The last four writes of every load that passed the init wait are 0xFF.
- R10: At the end of a load, cfg_ok is set if done is high and the s_last byte was taken, else cfg_err is set; the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration load (ignored while busy) |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte present |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Payload byte taken this cycle when s_valid is high |
| init_n | input | 1 | Target init line, active low, sampled only |
| done | input | 1 | Target done line, sampled only |
| program_n | output | 1 | Target program line, active low |
| wr_data | output | 8 | Byte written to the target |
| wr_stb | output | 1 | One-cycle write strobe |
| busy | output | 1 | Load in progress |
| cfg_ok | output | 1 | Last load succeeded |
| cfg_err | output | 1 | Last load failed |

## Verification
The bench builds the sequencer with PROG_LOW_CYC = 5, INIT_TMO_CYC = 40, GAP_CYC = 2 and two synchronizer stages. The short program pulse and timeout make the init timeout path quick to hit and let its duration be counted exactly. A nonzero gap makes the spacing rule observable between every pair of strobes. The loads use payloads of exactly two frames and of one frame plus four bytes, an init line that drops in the middle of the second frame, and done high from the outset. Together these cover the padding, the early-stop decisions and both end results.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_WAIT, ST_HDR, ST_PRE,
    ST_DATA, ST_CHK, ST_PAD, ST_BOOT, ST_FIN
  } seq_st_e;

  localparam int IDX_W      = 5;
  localparam int HDR_LEN    = 8;
  localparam int FRAME_DATA = 21;
  localparam int PAD_LEN    = 5;
  localparam int BOOT_LEN   = 4;

  localparam logic [7:0] CODE_FILL = 8'hFF;
  localparam logic [7:0] CODE_SYNC = 8'h4F;
  localparam logic [7:0] CODE_CHK  = 8'h4B;

  function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] i);
    case (i)
      5'd3:    return CODE_SYNC;
      5'd4:    return 8'h80;
      5'd5:    return 8'hAF;
      5'd6:    return 8'h9B;
      5'd7:    return CODE_CHK;
      default: return CODE_FILL;
    endcase
  endfunction

  function automatic logic [7:0] pad_byte(input logic [IDX_W-1:0] i);
    return (i == 5'd1) ? CODE_CHK : CODE_FILL;
  endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= (sh << 1) | STAGES'(d);
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cfgseq_pacer.sv
module cfgseq_pacer #(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic slot
);
  generate
    if (GAP_CYC == 0) begin : g_nogap
      assign slot = 1'b1;
    end else begin : g_gap
      localparam int GW = $clog2(GAP_CYC + 1);
      logic [GW-1:0] gap;

      always_ff @(posedge clk) begin
        if (rst)              gap <= '0;
        else if (fire)        gap <= GW'(GAP_CYC);
        else if (gap != '0)   gap <= gap - 1'b1;
      end

      assign slot = (gap == '0);

      p_gap_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
    end
  endgenerate
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import cfgseq_pkg::*;
#(
  parameter int PROG_LOW_CYC = 500,
  parameter int INIT_TMO_CYC = 2000000,
  parameter int GAP_CYC      = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       init_n,
  input  logic       done,
  output logic       program_n,
  output logic [7:0] wr_data,
  output logic       wr_stb,
  output logic       busy,
  output logic       cfg_ok,
  output logic       cfg_err
);
  localparam int TMAX = (PROG_LOW_CYC > INIT_TMO_CYC) ? PROG_LOW_CYC : INIT_TMO_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_LEN - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(FRAME_DATA - 1);
  localparam logic [IDX_W-1:0] PAD_LAST  = IDX_W'(PAD_LEN - 1);
  localparam logic [IDX_W-1:0] BOOT_LAST = IDX_W'(BOOT_LEN - 1);

  seq_st_e          st, st_nx;
  logic [IDX_W-1:0] idx, idx_nx;
  logic             ended;
  logic             prog_q, prog_nx;
  logic             ok_q, ok_nx, err_q, err_nx;
  logic             stb_q;
  logic [7:0]       data_q, byte_nx;
  logic             fire, take, slot;
  logic             init_s, done_s;
  logic             t_load, t_dec, t_zero;
  logic [TW-1:0]    t_val;

  cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_init (
    .clk(clk), .rst(rst), .d(init_n), .q(init_s));
  cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst(rst), .d(done), .q(done_s));

  cfgseq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .dec(t_dec), .zero(t_zero));

  cfgseq_pacer #(.GAP_CYC(GAP_CYC)) u_pacer (
    .clk(clk), .rst(rst), .fire(fire), .slot(slot));

  assign s_ready = (st == ST_DATA) && slot && !ended;
  assign t_dec   = (st == ST_PROG) || (st == ST_WAIT);

  always_comb begin
    st_nx   = st;
    idx_nx  = idx;
    fire    = 1'b0;
    take    = 1'b0;
    byte_nx = CODE_FILL;
    prog_nx = prog_q;
    ok_nx   = ok_q;
    err_nx  = err_q;
    t_load  = 1'b0;
    t_val   = '0;
    case (st)
      ST_IDLE: if (start) begin
        st_nx   = ST_PROG;
        prog_nx = 1'b0;
        ok_nx   = 1'b0;
        err_nx  = 1'b0;
        t_load  = 1'b1;
        t_val   = TW'(PROG_LOW_CYC - 1);
      end
      ST_PROG: if (t_zero) begin
        st_nx   = ST_WAIT;
        prog_nx = 1'b1;
        t_load  = 1'b1;
        t_val   = TW'(INIT_TMO_CYC - 1);
      end
      ST_WAIT: begin
        if (init_s) begin
          st_nx  = ST_HDR;
          idx_nx = '0;
        end else if (t_zero) begin
          st_nx  = ST_IDLE;
          err_nx = 1'b1;
        end
      end
      ST_HDR: if (slot) begin
        fire    = 1'b1;
        byte_nx = hdr_byte(idx);
        if (idx == HDR_LAST) begin st_nx = ST_PRE; idx_nx = '0; end
        else idx_nx = idx + 1'b1;
      end
      ST_PRE: if (slot) begin
        idx_nx = '0;
        if (init_s && !done_s && !ended) begin
          fire    = 1'b1;
          byte_nx = CODE_SYNC;
          st_nx   = ST_DATA;
        end else begin
          st_nx = ST_BOOT;
        end
      end
      ST_DATA: if (slot && (ended || s_valid)) begin
        fire    = 1'b1;
        take    = !ended;
        byte_nx = ended ? CODE_FILL : s_data;
        if (idx == DATA_LAST) begin st_nx = ST_CHK; idx_nx = '0; end
        else idx_nx = idx + 1'b1;
      end
      ST_CHK: if (slot) begin
        fire    = 1'b1;
        byte_nx = CODE_CHK;
        st_nx   = ST_PAD;
        idx_nx  = '0;
      end
      ST_PAD: if (slot) begin
        fire    = 1'b1;
        byte_nx = pad_byte(idx);
        if (idx == PAD_LAST) begin st_nx = ST_PRE; idx_nx = '0; end
        else idx_nx = idx + 1'b1;
      end
      ST_BOOT: if (slot) begin
        fire    = 1'b1;
        byte_nx = CODE_FILL;
        if (idx == BOOT_LAST) begin st_nx = ST_FIN; idx_nx = '0; end
        else idx_nx = idx + 1'b1;
      end
      ST_FIN: if (slot) begin
        ok_nx  = done_s && ended;
        err_nx = !(done_s && ended);
        st_nx  = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      idx    <= '0;
      ended  <= 1'b0;
      prog_q <= 1'b1;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      stb_q  <= 1'b0;
      data_q <= CODE_FILL;
    end else begin
      st     <= st_nx;
      idx    <= idx_nx;
      prog_q <= prog_nx;
      ok_q   <= ok_nx;
      err_q  <= err_nx;
      stb_q  <= fire;
      if (fire) data_q <= byte_nx;
      if (st == ST_IDLE && start) ended <= 1'b0;
      else if (take && s_last)    ended <= 1'b1;
    end
  end

  assign program_n = prog_q;
  assign wr_stb    = stb_q;
  assign wr_data   = data_q;
  assign busy      = (st != ST_IDLE);
  assign cfg_ok    = ok_q;
  assign cfg_err   = err_q;

  p_ok_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(cfg_ok && cfg_err));
  p_prog_in_load_r2: assert property (@(posedge clk) disable iff (rst)
    !program_n |-> busy);
  p_quiet_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> !wr_stb);
  p_stb_busy_r6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> busy);
  p_take_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (wr_stb && wr_data == $past(s_data)));
  p_no_ready_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && s_last) |=> !s_ready);
endmodule

// File: tb/sim_fpga_cfg_seq.sv
`timescale 1ns/1ps
module sim_fpga_cfg_seq;
  localparam int PL  = 5;
  localparam int TMO = 40;
  localparam int GAP = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, start, init_n, done_force, auto_done, src_en, clr;
  logic [7:0] s_data;
  logic       s_valid, s_last, s_ready, done;
  logic       program_n, wr_stb, busy, cfg_ok, cfg_err;
  logic [7:0] wr_data;

  logic [7:0] src [0:127];
  int src_len, ptr;
  logic [7:0] got [0:255];
  logic [7:0] exp_b [0:255];
  int ngot, nexp, gap_bad, plow, bcnt, cyc, last_cyc;
  int n_chk = 0, n_fail = 0;

  assign s_valid = src_en && (ptr < src_len);
  assign s_data  = (ptr < src_len) ? src[ptr[6:0]] : 8'h00;
  assign s_last  = (ptr == src_len - 1);
  assign done    = done_force | (auto_done && src_len > 0 && ptr == src_len);

  fpga_cfg_seq #(.PROG_LOW_CYC(PL), .INIT_TMO_CYC(TMO), .GAP_CYC(GAP),
                 .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .init_n(init_n), .done(done),
    .program_n(program_n), .wr_data(wr_data), .wr_stb(wr_stb), .busy(busy),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) ptr <= 0;
    else if (s_valid && s_ready) ptr <= ptr + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (clr) begin
      ngot = 0; gap_bad = 0; plow = 0; bcnt = 0; last_cyc = 0;
    end else begin
      if (!program_n) plow++;
      if (busy) bcnt++;
      if (wr_stb) begin
        if (ngot > 0 && cyc - last_cyc < GAP + 1) gap_bad++;
        last_cyc = cyc;
        if (ngot < 256) got[ngot] = wr_data;
        ngot++;
      end
    end
  end

  task automatic check(input bit c, input string req, input int act, input int expv);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b);
    exp_b[nexp] = b; nexp++;
  endtask

  task automatic build_exp(input int frames, input int avail, input bit booted);
    logic [7:0] hdr [0:7] = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    nexp = 0;
    if (!booted) return;
    for (int i = 0; i < 8; i++) push(hdr[i]);
    for (int f = 0; f < frames; f++) begin
      push(8'h4F);
      for (int j = 0; j < 21; j++) push((f*21 + j < avail) ? src[f*21 + j] : 8'hFF);
      push(8'h4B);
      push(8'hFF); push(8'h4B); push(8'hFF); push(8'hFF); push(8'hFF);
    end
    for (int i = 0; i < 4; i++) push(8'hFF);
  endtask

  task automatic compare_seq(input string req);
    int bad = -1;
    check(ngot == nexp, {req, " write count"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      if (bad < 0 && got[i] != exp_b[i]) bad = i;
    if (bad >= 0) check(0, {req, " write byte"}, got[bad], exp_b[bad]);
    else check(1, req, 0, 0);
  endtask

  task automatic setup(input int len, input int seed);
    for (int i = 0; i < len; i++) src[i] = 8'((i * 37 + seed) ^ 8'h5A);
    @(negedge clk);
    src_len = len; src_en = 1'b1; init_n = 1'b0; done_force = 1'b0; auto_done = 1'b1;
    clr = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic launch(input int init_delay);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (init_delay >= 0) begin
      repeat (init_delay) @(negedge clk);
      init_n = 1'b1;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(program_n == 1'b1, "R1 program_n", program_n, 1);
    check(!wr_stb && !busy, "R1 strobe/busy", {wr_stb, busy}, 0);
    check(!cfg_ok && !cfg_err, "R1 result flags", {cfg_ok, cfg_err}, 0);
    check(!s_ready, "R1 s_ready", s_ready, 0);
  endtask

  task automatic t_full();
    setup(42, 3);
    launch(10);
    wait_idle();
    build_exp(2, 42, 1'b1);
    for (int i = 0; i < 8; i++) check(got[i] == exp_b[i], "R4 header byte", got[i], exp_b[i]);
    compare_seq("R5 two full frames");
    check(plow == PL, "R2 program pulse width", plow, PL);
    check(gap_bad == 0, "R6 strobe spacing", gap_bad, 0);
    check(ptr == 42, "R7 bytes consumed", ptr, 42);
    check(cfg_ok && !cfg_err, "R10 success flag", {cfg_ok, cfg_err}, 2);
    for (int i = nexp - 4; i < nexp; i++) check(got[i] == 8'hFF, "R9 startup byte", got[i], 8'hFF);
  endtask

  task automatic t_short();
    setup(25, 11);
    launch(4);
    wait_idle();
    build_exp(2, 25, 1'b1);
    compare_seq("R7 padded last frame");
    check(ptr == 25, "R7 bytes consumed", ptr, 25);
    check(gap_bad == 0, "R6 strobe spacing", gap_bad, 0);
    check(cfg_ok && !cfg_err, "R10 success flag", {cfg_ok, cfg_err}, 2);
  endtask

  task automatic t_init_drop();
    setup(63, 29);
    launch(6);
    while (ptr < 30) @(negedge clk);
    init_n = 1'b0;
    wait_idle();
    build_exp(2, 63, 1'b1);
    compare_seq("R8 stop after init drop");
    check(ptr == 42, "R8 bytes consumed", ptr, 42);
    check(cfg_err && !cfg_ok, "R10 failure flag", {cfg_ok, cfg_err}, 1);
  endtask

  task automatic t_done_early();
    setup(21, 7);
    done_force = 1'b1;
    launch(3);
    wait_idle();
    build_exp(0, 0, 1'b1);
    compare_seq("R9 header then startup");
    check(ptr == 0, "R8 no payload taken", ptr, 0);
    check(cfg_err && !cfg_ok, "R10 failure flag", {cfg_ok, cfg_err}, 1);
  endtask

  task automatic t_timeout();
    setup(21, 1);
    launch(-1);
    wait_idle();
    check(ngot == 0, "R3 no writes before init", ngot, 0);
    check(cfg_err && !cfg_ok, "R3 timeout error", {cfg_ok, cfg_err}, 1);
    check(bcnt == PL + TMO, "R3 timeout duration", bcnt, PL + TMO);
    check(plow == PL, "R2 program pulse width", plow, PL);
    check(ptr == 0 && program_n, "R3 idle after timeout", ptr, 0);
  endtask

  initial begin
    cyc = 0; ptr = 0; rst = 1'b1; start = 1'b0; init_n = 1'b0; done_force = 1'b0;
    auto_done = 1'b0; src_en = 1'b0; src_len = 0; clr = 1'b1;
    ngot = 0; nexp = 0; gap_bad = 0; plow = 0; bcnt = 0; last_cyc = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_short();
    t_init_drop();
    t_done_early();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule